// File: doc/BRIEF.md
# Truth-Table-Selected Arithmetic/Logic Unit

This block is a combinational arithmetic/logic unit built from 4-bit slices. A 4-bit select word is read as the output column of a two-input truth table, so any of the sixteen Boolean functions of two operand bits can be picked. A mode input chooses between that Boolean result and an arithmetic result.

In arithmetic mode each bit forms a propagate term and a generate term from its operand bits and the select word. The unit then adds these two terms as words, with an active-high carry input. Inside a slice, all carries come from flat lookahead sums of products of propagate, generate and the carry input. No carry ripples from bit to bit inside a slice.

Each slice reports group propagate and group generate. Slices are joined by passing the carry out of one slice to the carry in of the next. The default build joins two slices into an 8-bit unit. The top also gives the group terms for the whole width and an all-ones flag. That flag doubles as an operand-equality indicator when the unit subtracts.

Top module: `fs_alu`

## Requirements
- R1: With `logic_mode_i`=1, each bit of `f_o` depends only on that bit of A and B. The values are: (a=0,b=0) gives NOT sel[1]; (a=0,b=1) gives NOT sel[0]; (a=1,b=0) gives sel[2]; (a=1,b=1) gives sel[3]. `carry_i` has no effect on `f_o` in this mode.
- R2: With `logic_mode_i`=0, `f_o` = (A | T1) + (A & T2) + `carry_i`, modulo 2^W. Here T1 is the word whose bit i is (b_i & sel[0]) | (~b_i & sel[1]), and T2 is the word whose bit i is (b_i & sel[3]) | (~b_i & sel[2]).
- R3: `carry_o` is bit W of the full sum in R2. It has that value in both modes.
- R4: Named arithmetic cases follow from R2. sel=1001 with carry 0 gives A+B. sel=0110 with carry 1 gives A-B. sel=0000 with carry 1 gives A+1. sel=1111 with carry 0 gives A-1.
- R5: `equal_o` is 1 exactly when every bit of `f_o` is 1. With sel=0110, arithmetic mode and carry 0, it is 1 exactly when A equals B.
- R6: `grp_prop_o` is 1 exactly when (A | T1) is all ones. `grp_gen_o` equals the carry out of (A | T1) + (A & T2) with zero carry in. Both are independent of the mode and of `carry_i`.
- R7: The carry crosses the slice boundary. A=0x0F, B=0x01 under A+B gives 0x10 with no carry out. A=0xFF, B=0x01 gives 0x00 with carry out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (8) | Operand A |
| b_i | input | W (8) | Operand B |
| sel_i | input | 4 | Truth-table column selecting the function |
| logic_mode_i | input | 1 | 1 selects the Boolean result, 0 the arithmetic result |
| carry_i | input | 1 | Active-high carry into the lowest bit |
| f_o | output | W (8) | Result |
| carry_o | output | 1 | Active-high carry out of the top bit |
| grp_prop_o | output | 1 | Group propagate over the whole width |
| grp_gen_o | output | 1 | Group generate over the whole width |
| equal_o | output | 1 | All result bits are one |

## Verification
The block holds no state, so any wrong internal term appears at the ports as soon as the inputs settle. A wrong per-bit propagate or generate term shows up in that bit of `f_o` in logic mode. A wrong lookahead product shows up only in arithmetic mode, and only for operand pairs whose carry chain passes through the faulty term. Such pairs are found by sweeping every select value in both modes with both carry inputs over random operands. A broken link between slices shows up in the top nibble and in `carry_o` when the low slice overflows.

// File: rtl/fs_alu_pkg.sv
package fs_alu_pkg;

  // Propagate: A or the first selected B term.
  function automatic logic bit_prop(input logic a, input logic b, input logic [3:0] s);
    return a | (b & s[0]) | (~b & s[1]);
  endfunction

  // Generate: A and the second selected B term.
  function automatic logic bit_gen(input logic a, input logic b, input logic [3:0] s);
    return a & ((b & s[3]) | (~b & s[2]));
  endfunction

  // Truth-table column as seen in logic mode, indexed by {a,b}.
  function automatic logic [3:0] logic_column(input logic [3:0] s);
    return {s[3], s[2], ~s[0], ~s[1]};
  endfunction

endpackage

// File: rtl/fs_alu_pg.sv
module fs_alu_pg
  import fs_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   sel_i,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] gen_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop_o[i] = bit_prop(a_i[i], b_i[i], sel_i);
    assign gen_o[i]  = bit_gen(a_i[i], b_i[i], sel_i);
  end

  // A bit can only generate where it also propagates (R6 relies on it).
  always_comb begin
    p_gen_within_prop_r6: assert ((gen_o & ~prop_o) == '0)
      else $error("generate outside propagate");
  end

endmodule

// File: rtl/fs_alu_carry.sv
module fs_alu_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] gen_i,
  input  logic         cin_i,
  output logic [W:0]   carry_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);

  // AND of prop over bit range [lo,hi]; an empty range yields 1.
  function automatic logic span_and(input logic [W-1:0] v, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (k >= lo && k <= hi) r = r & v[k];
    end
    return r;
  endfunction

  assign carry_o[0] = cin_i;

  // Flat sum of products per carry: no bit-to-bit ripple.
  for (genvar i = 0; i < W; i++) begin : g_la
    logic acc;
    always_comb begin
      acc = cin_i & span_and(prop_i, 0, i);
      for (int j = 0; j <= i; j++) begin
        acc = acc | (gen_i[j] & span_and(prop_i, j + 1, i));
      end
    end
    assign carry_o[i+1] = acc;
  end

  logic gg_acc;
  always_comb begin
    gg_acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      gg_acc = gg_acc | (gen_i[j] & span_and(prop_i, j + 1, W - 1));
    end
  end
  assign grp_gen_o  = gg_acc;
  assign grp_prop_o = span_and(prop_i, 0, W - 1);

  // Lookahead must agree with the serial recurrence at every bit (R3).
  always_comb begin
    for (int i = 0; i < W; i++) begin
      p_carry_recur_r3: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])))
        else $error("lookahead carry %0d disagrees with recurrence", i + 1);
    end
    p_group_carry_r6: assert (carry_o[W] == (grp_gen_o | (grp_prop_o & cin_i)))
      else $error("group terms disagree with carry out");
  end

endmodule

// File: rtl/fs_alu_slice.sv
module fs_alu_slice
  import fs_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   sel_i,
  input  logic         logic_mode_i,
  input  logic         carry_i,
  output logic [W-1:0] f_o,
  output logic         carry_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o,
  output logic         ones_o
);

  logic [W-1:0] prop, gen;
  logic [W:0]   carry;
  logic [W-1:0] carry_used;

  fs_alu_pg #(.W(W)) u_pg (
    .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .prop_o(prop), .gen_o(gen)
  );

  fs_alu_carry #(.W(W)) u_carry (
    .prop_i(prop), .gen_i(gen), .cin_i(carry_i),
    .carry_o(carry), .grp_prop_o(grp_prop_o), .grp_gen_o(grp_gen_o)
  );

  // Logic mode forces the carry term to one, which inverts P^G.
  assign carry_used = logic_mode_i ? {W{1'b1}} : carry[W-1:0];
  assign f_o        = prop ^ gen ^ carry_used;
  assign carry_o    = carry[W];
  assign ones_o     = &f_o;

  // Logic mode reproduces the selected truth-table column per bit (R1).
  logic [3:0] col;
  assign col = logic_column(sel_i);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      p_logic_column_r1: assert (!logic_mode_i || (f_o[i] == col[{a_i[i], b_i[i]}]))
        else $error("logic bit %0d off the truth table", i);
    end
  end

endmodule

// File: rtl/fs_alu.sv
module fs_alu #(
  parameter  int SLICE_W = 4,
  parameter  int SLICES  = 2,
  localparam int W       = SLICE_W * SLICES
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   sel_i,
  input  logic         logic_mode_i,
  input  logic         carry_i,
  output logic [W-1:0] f_o,
  output logic         carry_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o,
  output logic         equal_o
);

  logic [SLICES:0]   link;
  logic [SLICES-1:0] sp, sg, sones;

  assign link[0] = carry_i;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    fs_alu_slice #(.W(SLICE_W)) u_slice (
      .a_i          (a_i[k*SLICE_W +: SLICE_W]),
      .b_i          (b_i[k*SLICE_W +: SLICE_W]),
      .sel_i        (sel_i),
      .logic_mode_i (logic_mode_i),
      .carry_i      (link[k]),
      .f_o          (f_o[k*SLICE_W +: SLICE_W]),
      .carry_o      (link[k+1]),
      .grp_prop_o   (sp[k]),
      .grp_gen_o    (sg[k]),
      .ones_o       (sones[k])
    );
  end

  assign carry_o = link[SLICES];
  assign equal_o = &sones;

  logic gg_acc;
  always_comb begin
    gg_acc = 1'b0;
    for (int k = 0; k < SLICES; k++) gg_acc = sg[k] | (sp[k] & gg_acc);
  end
  assign grp_gen_o  = gg_acc;
  assign grp_prop_o = &sp;

  // Whole-width restatement as a word addition (R2, R3).
  logic [W-1:0] t1w, t2w;
  logic [W:0]   word_sum;
  assign t1w      = (b_i & {W{sel_i[0]}}) | (~b_i & {W{sel_i[1]}});
  assign t2w      = (b_i & {W{sel_i[3]}}) | (~b_i & {W{sel_i[2]}});
  assign word_sum = {1'b0, a_i | t1w} + {1'b0, a_i & t2w} + {{W{1'b0}}, carry_i};

  always_comb begin
    p_arith_sum_r2: assert (logic_mode_i || (f_o == word_sum[W-1:0]))
      else $error("arithmetic result off");
    p_carry_out_r3: assert (carry_o == word_sum[W])
      else $error("carry out off");
    p_sub_equal_r5: assert (logic_mode_i || carry_i || (sel_i != 4'b0110)
                            || (equal_o == (a_i == b_i)))
      else $error("equality flag off under subtract");
  end

endmodule

// File: tb/fs_alu_tb.sv
module fs_alu_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b;
  logic [3:0]   sel;
  logic         lm, cin;
  logic [W-1:0] f;
  logic         cout, gp, gg, eq;

  fs_alu u_dut (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(lm), .carry_i(cin),
    .f_o(f), .carry_o(cout), .grp_prop_o(gp), .grp_gen_o(gg), .equal_o(eq)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      bad  = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---- bench models ----
  function automatic logic [W-1:0] m_x(input logic [W-1:0] aa, bb, input logic [3:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = aa[i] | (bb[i] ? s[0] : s[1]);
    return r;
  endfunction

  function automatic logic [W-1:0] m_y(input logic [W-1:0] aa, bb, input logic [3:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = aa[i] & (bb[i] ? s[3] : s[2]);
    return r;
  endfunction

  function automatic logic [W:0] m_sum(input logic [W-1:0] aa, bb, input logic [3:0] s, input logic c);
    return {1'b0, m_x(aa, bb, s)} + {1'b0, m_y(aa, bb, s)} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] m_f(input logic [W-1:0] aa, bb, input logic [3:0] s,
                                       input logic m, input logic c);
    logic [W-1:0] r;
    logic [W:0]   t;
    if (m) begin
      for (int i = 0; i < W; i++) begin
        case ({aa[i], bb[i]})
          2'b00: r[i] = ~s[1];
          2'b01: r[i] = ~s[0];
          2'b10: r[i] = s[2];
          default: r[i] = s[3];
        endcase
      end
    end else begin
      t = m_sum(aa, bb, s, c);
      r = t[W-1:0];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h sel=%b m=%b c=%b)",
               req, got, exp, a, b, sel, lm, cin);
    end
  endtask

  task automatic apply(input logic [W-1:0] aa, bb, input logic [3:0] s, input logic m, input logic c);
    @(posedge clk);
    a = aa; b = bb; sel = s; lm = m; cin = c;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [W:0] s9;
    s9 = m_sum(a, b, sel, cin);
    chk(lm ? "R1" : "R2", f, m_f(a, b, sel, lm, cin));
    chk("R3", cout, s9[W]);
    chk("R5", eq, &m_f(a, b, sel, lm, cin));
    chk("R6 gp", gp, &m_x(a, b, sel));
    s9 = m_sum(a, b, sel, 1'b0);
    chk("R6 gg", gg, s9[W]);
  endtask

  logic [W-1:0] keep;

  initial begin
    void'($urandom(32'h1f2e3d4c));
    a = '0; b = '0; sel = '0; lm = 1'b1; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Initial state: all-zero operands, logic mode, sel 0000 -> all ones.
    chk("R1 initial", f, 8'hFF);
    chk("R5 initial", eq, 1'b1);

    // Full sweep of select, mode and carry over random operands.
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 2; c++) begin
          for (int n = 0; n < 24; n++) begin
            apply(W'($urandom), W'($urandom), 4'(s), 1'(m), 1'(c));
            check_all();
          end
          apply('0, '0, 4'(s), 1'(m), 1'(c));  check_all();
          apply('1, '1, 4'(s), 1'(m), 1'(c));  check_all();
          apply('1, '0, 4'(s), 1'(m), 1'(c));  check_all();
        end
      end
    end

    // R1: carry in has no effect in logic mode.
    for (int n = 0; n < 16; n++) begin
      apply(W'($urandom), W'($urandom), 4'(n), 1'b1, 1'b0);
      keep = f;
      apply(a, b, sel, 1'b1, 1'b1);
      chk("R1 carry ignored", f, keep);
    end

    // R4: named arithmetic cases.
    apply(8'h3C, 8'h45, 4'b1001, 1'b0, 1'b0); chk("R4 add", f, 8'h81);
    apply(8'h50, 8'h21, 4'b0110, 1'b0, 1'b1); chk("R4 sub", f, 8'h2F);
    apply(8'h10, 8'h20, 4'b0110, 1'b0, 1'b1); chk("R4 sub wrap", f, 8'hF0);
    chk("R4 sub borrow", cout, 1'b0);
    apply(8'hFF, 8'h00, 4'b0000, 1'b0, 1'b1); chk("R4 inc", f, 8'h00);
    chk("R4 inc carry", cout, 1'b1);
    apply(8'h00, 8'h5A, 4'b1111, 1'b0, 1'b0); chk("R4 dec", f, 8'hFF);

    // R5: equality under subtract.
    apply(8'hA7, 8'hA7, 4'b0110, 1'b0, 1'b0); chk("R5 equal", eq, 1'b1);
    apply(8'hA7, 8'hA6, 4'b0110, 1'b0, 1'b0); chk("R5 unequal", eq, 1'b0);

    // R6: group terms independent of mode and carry.
    apply(8'hF0, 8'h0F, 4'b1001, 1'b1, 1'b1);
    chk("R6 gp logic", gp, 1'b1);
    chk("R6 gg logic", gg, 1'b0);

    // R7: carry across the slice boundary.
    apply(8'h0F, 8'h01, 4'b1001, 1'b0, 1'b0);
    chk("R7 cross", f, 8'h10);
    chk("R7 cross carry", cout, 1'b0);
    apply(8'hFF, 8'h01, 4'b1001, 1'b0, 1'b0);
    chk("R7 wrap", f, 8'h00);
    chk("R7 wrap carry", cout, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule